// File: doc/BRIEF.md
# DMA Port-Size Bus Cycle Splitter

This block sits between a DMA channel's transfer engine and a narrow device port. It takes one transfer of 32, 16 or 8 bits and issues as many bus cycles as the port width needs to carry it. Each bus cycle completes with a valid/ready handshake. The least significant part goes first.

On a read, the block gathers the narrow beats into a 32-bit word. On a write, it takes the held word apart and sends it out one slice per beat. Memory-type targets see the address rise by the port width on every beat. I/O-type targets see one fixed address, so every beat uses the low data lanes. If the port is wider than the transfer, the block flags a configuration error and drives no bus cycle. When the last beat completes, a one-clock done pulse follows, and the gathered read word is valid in that same clock.

Top module: `dma_port_splitter`

## Requirements
- R1: After reset, `bus_valid`, `busy`, `done` and `cfg_err` are all low.
- R2: Size codes apply to both `xfer_size` and `port_size`: 2'b00 and 2'b01 mean 32 bits, 2'b10 means 16 bits, 2'b11 means 8 bits. A 32-bit transfer takes 1, 2 or 4 bus cycles on a 32-, 16- or 8-bit port.
- R3: A 16-bit transfer takes 1 bus cycle on a 16-bit port and 2 bus cycles on an 8-bit port.
- R4: An 8-bit transfer on an 8-bit port takes one bus cycle. Code 2'b01 behaves exactly like 2'b00.
- R5: If the port is wider than the transfer, the start is rejected. `cfg_err` is high for exactly the clock after the start edge, and no bus cycle and no `done` follow.
- R6: A read places beat k, taken from the low port-width bits of `bus_rdata`, at bit offset k times the port width in `rdata`. Bits above the transfer size are zero.
- R7: On a write, beat k drives bits [k*W +: W] of the captured `wdata` onto `bus_wdata[W-1:0]`, where W is the port width. Lanes above W are zero.
- R8: For a memory target (`is_io`=0), beat 0 uses `base_addr`, and each later beat adds the port width in bytes.
- R9: For an I/O target (`is_io`=1), every beat uses `base_addr`.
- R10: `done` is high for one clock, starting the clock after the last handshake edge. `busy` is low in that clock, and on a read `rdata` holds the gathered word then.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_we` and `bus_wdata` hold their values.
- R12: A `start` while `busy` is high is ignored. The running transfer's beats, addresses and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer; sampled when not busy |
| xfer_size | input | 2 | Transfer size code |
| port_size | input | 2 | Device port size code |
| is_write | input | 1 | 1 for write, 0 for read |
| is_io | input | 1 | 1 for a fixed-address I/O target |
| base_addr | input | ADDR_W | Address of beat 0 |
| wdata | input | 32 | Write word, captured at start |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | Forbidden size combination rejected |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Gathered read word |
| bus_valid | output | 1 | Bus cycle request |
| bus_ready | input | 1 | Bus cycle accepted |
| bus_we | output | 1 | Bus cycle direction |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 32 | Write data on the low lanes |
| bus_rdata | input | 32 | Read data on the low lanes |

## Verification
Each result has a fixed arrival time:
- The first beat's `bus_valid` rises one clock after the start edge.
- A rejected start shows `cfg_err` in that same clock.
- `done` and `rdata` arrive one clock after the edge where the last `bus_valid`/`bus_ready` pair was high.

The bench drives inputs and samples outputs on falling edges. A beat is counted when valid and ready are both high at a falling edge, since that is the pair the next rising edge takes. The driver queues the expected beats and the expected read word. The monitor checks each beat as it appears, and it checks the completion entry on the falling edge where `done` is first seen. Wait states come from a ready that toggles every clock, which lets the bench check that a stalled beat holds its address.

// File: rtl/dps_pkg.sv
// Shared size encoding and helpers for the port-size splitter.
// Assumes a 32-bit transfer word; size codes are 2 bits wide.
package dps_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_32A = 2'b00,
        SZ_32B = 2'b01,
        SZ_16  = 2'b10,
        SZ_8   = 2'b11
    } size_code_t;

    // Map a size code to log2 of its width in bytes (2, 1 or 0).
    function automatic logic [1:0] size_lg(input logic [1:0] code);
        case (code)
            SZ_16:   return 2'd1;
            SZ_8:    return 2'd0;
            default: return 2'd2;
        endcase
    endfunction

    // Low-lane mask for a port of the given byte width log2.
    function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/dps_decode.sv
// Size decoder: turns the transfer and port size codes into a beat count
// and port width, and flags forbidden combinations (port wider than transfer).
// Purely combinational; assumes codes are stable while start is high.
module dps_decode
    import dps_pkg::*;
(
    input  logic [1:0] xfer_code,
    input  logic [1:0] port_code,
    output logic       forbidden,
    output logic [1:0] last_idx,
    output logic [1:0] port_lg
);
    logic [1:0] xfer_lg;
    logic [1:0] ratio_lg;

    // Decode widths, legality and index of the final beat.
    always_comb begin
        xfer_lg   = size_lg(xfer_code);
        port_lg   = size_lg(port_code);
        forbidden = (port_lg > xfer_lg);
        ratio_lg  = forbidden ? 2'd0 : (xfer_lg - port_lg);
        case (ratio_lg)
            2'd0:    last_idx = 2'd0;
            2'd1:    last_idx = 2'd1;
            default: last_idx = 2'd3;
        endcase
    end
endmodule

// File: rtl/dps_seq.sv
// Beat sequencer: counts handshakes for one transfer, steps the address for
// memory targets, raises done after the last beat and flags rejected starts.
// Assumes launch and reject are never high together and only when idle.
module dps_seq #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              reject,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              is_io,
    input  logic [1:0]        last_in,
    input  logic [1:0]        plg_in,
    input  logic              bus_ready,
    output logic              busy,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        beat_idx,
    output logic              beat_fire,
    output logic [1:0]        plg_q,
    output logic              done,
    output logic              cfg_err
);
    logic              io_q;
    logic [1:0]        last_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] step;
    logic              final_beat;

    // Address step and handshake decode.
    always_comb begin
        step       = ADDR_W'(1) << plg_q;
        beat_fire  = busy && bus_ready;
        final_beat = (beat_idx == last_q);
        bus_valid  = busy;
        bus_addr   = addr_q;
    end

    // Sequence state: launch, per-beat advance, completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cfg_err  <= 1'b0;
            beat_idx <= 2'd0;
            last_q   <= 2'd0;
            plg_q    <= 2'd2;
            io_q     <= 1'b0;
            addr_q   <= '0;
        end else begin
            done    <= 1'b0;
            cfg_err <= reject;
            if (launch) begin
                busy     <= 1'b1;
                beat_idx <= 2'd0;
                last_q   <= last_in;
                plg_q    <= plg_in;
                io_q     <= is_io;
                addr_q   <= base_addr;
            end else if (beat_fire) begin
                if (final_beat) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    beat_idx <= beat_idx + 2'd1;
                    if (!io_q) addr_q <= addr_q + step;
                end
            end
        end
    end

    a_r5_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !bus_valid && !done);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr));
    a_r9_io_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        beat_fire && io_q && !final_beat |=> $stable(bus_addr));
    a_r8_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
        beat_fire && !io_q && !final_beat |=>
            bus_addr == $past(bus_addr) + (ADDR_W'(1) << $past(plg_q)));
    a_r2_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> beat_idx <= last_q);
    a_r12_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !beat_fire |=> busy && $stable(beat_idx));
endmodule

// File: rtl/dps_pack.sv
// Data path: holds the write word and slices it onto the low port lanes per
// beat, or gathers narrow read beats into the word, least significant first.
// Assumes beat_idx and port_lg come from the sequencer for the current beat.
module dps_pack
    import dps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              beat_fire,
    input  logic [1:0]        beat_idx,
    input  logic [1:0]        port_lg,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              bus_we,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] word
);
    logic              we_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] mask;
    logic [5:0]        shamt;

    // Lane selection for the current beat.
    always_comb begin
        mask      = lane_mask(port_lg);
        shamt     = 6'(beat_idx) << (3 + port_lg);
        bus_wdata = (word_q >> shamt) & mask;
        bus_we    = we_q;
        word      = word_q;
    end

    // Capture the write word or clear for a read; merge read beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            word_q <= '0;
        end else if (load) begin
            we_q   <= load_we;
            word_q <= load_we ? wdata : '0;
        end else if (beat_fire && !we_q) begin
            word_q <= word_q | ((bus_rdata & mask) << shamt);
        end
    end

    a_r6_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !(beat_fire && !we_q) |=> $stable(word_q));
    a_r7_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bus_we));
endmodule

// File: rtl/dma_port_splitter.sv
// Top: accepts one DMA transfer, rejects forbidden size pairs, and drives the
// narrow bus one handshake per beat. Assumes start is ignored while busy.
module dma_port_splitter
    import dps_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        xfer_size,
    input  logic [1:0]        port_size,
    input  logic              is_write,
    input  logic              is_io,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [31:0]       wdata,
    output logic              busy,
    output logic              cfg_err,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);
    logic       forbidden;
    logic [1:0] last_idx;
    logic [1:0] port_lg;
    logic [1:0] plg_q;
    logic [1:0] beat_idx;
    logic       beat_fire;
    logic       launch;
    logic       reject;

    // Accept a start only when idle; split it into launch or reject.
    always_comb begin
        launch = start && !busy && !forbidden;
        reject = start && !busy && forbidden;
    end

    dps_decode u_decode (
        .xfer_code (xfer_size),
        .port_code (port_size),
        .forbidden (forbidden),
        .last_idx  (last_idx),
        .port_lg   (port_lg)
    );

    dps_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .reject    (reject),
        .base_addr (base_addr),
        .is_io     (is_io),
        .last_in   (last_idx),
        .plg_in    (port_lg),
        .bus_ready (bus_ready),
        .busy      (busy),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .beat_idx  (beat_idx),
        .beat_fire (beat_fire),
        .plg_q     (plg_q),
        .done      (done),
        .cfg_err   (cfg_err)
    );

    dps_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .load_we   (is_write),
        .wdata     (wdata),
        .beat_fire (beat_fire),
        .beat_idx  (beat_idx),
        .port_lg   (plg_q),
        .bus_rdata (bus_rdata),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .word      (rdata)
    );
endmodule

// File: tb/test_dma_port_splitter.sv
// Scoreboard bench: the driver queues expected beats and results; the
// monitor compares them at falling edges as the design produces them.
module test_dma_port_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  xfer_size = 2'b00;
    logic [1:0]  port_size = 2'b00;
    logic        is_write = 1'b0;
    logic        is_io = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] wdata = '0;
    logic        busy, cfg_err, done, bus_valid, bus_we;
    logic [31:0] rdata, bus_addr, bus_wdata, bus_rdata;
    logic        bus_ready;
    logic        wait_mode = 1'b0;
    logic [31:0] cyc = '0;
    logic [7:0]  beat = '0;

    typedef struct packed {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wd;
    } beat_t;
    typedef struct packed {
        logic        we;
        logic [31:0] word;
    } res_t;

    beat_t beat_q[$];
    res_t  res_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    done_cnt = 0;
    bit    stalled = 1'b0;
    logic [31:0] stall_addr = '0;
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    assign bus_ready = !wait_mode || cyc[0];
    assign bus_rdata = {8'h5A, 8'h40 + beat, 8'h20 + beat, 8'h10 + beat};

    dma_port_splitter #(.ADDR_W(32)) i_dma_port_splitter (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_size(xfer_size),
        .port_size(port_size), .is_write(is_write), .is_io(is_io),
        .base_addr(base_addr), .wdata(wdata), .busy(busy), .cfg_err(cfg_err),
        .done(done), .rdata(rdata), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Free-running cycle count and per-transfer beat index for read data.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (start && !busy) beat <= '0;
        else if (bus_valid && bus_ready) beat <= beat + 8'd1;
    end

    // Monitor: compare each beat and each completion against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stalled)
                chk(bus_valid && bus_addr == stall_addr, "R11 stall hold", bus_addr, stall_addr);
            stalled    = bus_valid && !bus_ready;
            stall_addr = bus_addr;
            if (bus_valid && bus_ready) begin
                if (beat_q.size() == 0) begin
                    chk(1'b0, "R2 R3 R4 extra beat", bus_addr, 32'h0);
                end else begin
                    beat_t e;
                    e = beat_q.pop_front();
                    chk(bus_addr == e.addr, "R8 R9 beat address", bus_addr, e.addr);
                    chk(bus_we == e.we, "R7 beat direction", 32'(bus_we), 32'(e.we));
                    if (e.we) chk(bus_wdata == e.wd, "R7 write lanes", bus_wdata, e.wd);
                end
            end
            if (done) begin
                done_cnt++;
                chk(!busy, "R10 busy low at done", 32'(busy), 32'h0);
                chk(beat_q.size() == 0, "R2 R3 R4 beats missing", 32'(beat_q.size()), 32'h0);
                if (res_q.size() == 0) begin
                    chk(1'b0, "R5 R12 unexpected done", 32'h1, 32'h0);
                end else begin
                    res_t r;
                    r = res_q.pop_front();
                    if (!r.we) chk(rdata == r.word, "R6 R10 read word", rdata, r.word);
                end
            end
        end
    end

    function automatic int lg_of(input logic [1:0] c);
        return (c == 2'b10) ? 1 : (c == 2'b11) ? 0 : 2;
    endfunction

    // Driver: queue expectations for one transfer, start it and await done.
    task automatic xfer(input logic [1:0] xs, input logic [1:0] ps, input bit we,
                        input bit io, input logic [31:0] base,
                        input logic [31:0] wd, input bit waits, input bit poke);
        int xl, pl, n, d0;
        logic [31:0] exp_word, lanes, pmask, xmask;
        xl = lg_of(xs);
        pl = lg_of(ps);
        @(negedge clk);
        wait_mode = waits;
        xfer_size = xs; port_size = ps; is_write = we; is_io = io;
        base_addr = base; wdata = wd;
        if (pl > xl) begin
            d0 = done_cnt;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(cfg_err == 1'b1, "R5 error pulse", 32'(cfg_err), 32'h1);
            chk(!bus_valid && !busy, "R5 no bus cycle", 32'(bus_valid), 32'h0);
            @(negedge clk);
            chk(cfg_err == 1'b0, "R5 error one clock", 32'(cfg_err), 32'h0);
            repeat (3) @(negedge clk);
            chk(done_cnt == d0 && !bus_valid, "R5 no done", 32'(done_cnt), 32'(d0));
            return;
        end
        n = 1 << (xl - pl);
        pmask = (pl == 2) ? 32'hFFFF_FFFF : (pl == 1) ? 32'h0000_FFFF : 32'h0000_00FF;
        xmask = (xl == 2) ? 32'hFFFF_FFFF : (xl == 1) ? 32'h0000_FFFF : 32'h0000_00FF;
        exp_word = '0;
        for (int k = 0; k < n; k++) begin
            beat_t b;
            b.addr = io ? base : base + 32'(k << pl);
            b.we   = we;
            b.wd   = (wd >> (k * (8 << pl))) & pmask;
            beat_q.push_back(b);
            lanes = {8'h5A, 8'h40 + 8'(k), 8'h20 + 8'(k), 8'h10 + 8'(k)} & pmask;
            exp_word |= lanes << (k * (8 << pl));
        end
        res_q.push_back('{we: we, word: exp_word & xmask});
        d0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(bus_valid == 1'b1, "R2 first beat one clock after start", 32'(bus_valid), 32'h1);
        if (poke) begin
            // R12: a second start with other settings while busy.
            xfer_size = 2'b11; port_size = 2'b11; is_write = ~we; is_io = ~io;
            base_addr = 32'hDEAD_0000; wdata = 32'hFFFF_FFFF;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R12 still busy", 32'(busy), 32'h1);
        end
        for (int t = 0; t < 200 && done_cnt == d0; t++) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10 done seen", 32'(done_cnt), 32'(d0 + 1));
        @(negedge clk);
        chk(!done && !busy, "R10 done one clock", 32'(done), 32'h0);
        wait_mode = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_valid && !busy && !done && !cfg_err, "R1 reset state",
            {28'h0, bus_valid, busy, done, cfg_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_valid && !busy, "R1 idle after reset", 32'(bus_valid), 32'h0);
        // R2: 32-bit transfers on each port width.
        xfer(2'b00, 2'b00, 1'b0, 1'b0, 32'h0000_1000, 32'h0, 1'b0, 1'b0);
        xfer(2'b00, 2'b10, 1'b0, 1'b0, 32'h0000_2000, 32'h0, 1'b0, 1'b0);
        xfer(2'b00, 2'b11, 1'b0, 1'b0, 32'h0000_3000, 32'h0, 1'b1, 1'b0);
        xfer(2'b00, 2'b11, 1'b1, 1'b1, 32'h0000_0040, 32'hA1B2_C3D4, 1'b0, 1'b0);
        xfer(2'b00, 2'b10, 1'b1, 1'b0, 32'h0000_4000, 32'h1357_9BDF, 1'b1, 1'b0);
        // R3: 16-bit transfers.
        xfer(2'b10, 2'b10, 1'b0, 1'b0, 32'h0000_5000, 32'h0, 1'b0, 1'b0);
        xfer(2'b10, 2'b11, 1'b0, 1'b1, 32'h0000_0080, 32'h0, 1'b1, 1'b0);
        xfer(2'b10, 2'b11, 1'b1, 1'b0, 32'h0000_6001, 32'hFFFF_BEEF, 1'b0, 1'b0);
        // R4: 8-bit transfers and the alternate 32-bit code.
        xfer(2'b11, 2'b11, 1'b0, 1'b0, 32'h0000_7003, 32'h0, 1'b0, 1'b0);
        xfer(2'b11, 2'b11, 1'b1, 1'b1, 32'h0000_00C0, 32'h0000_0077, 1'b0, 1'b0);
        xfer(2'b01, 2'b11, 1'b1, 1'b0, 32'h0000_8000, 32'h0102_0304, 1'b0, 1'b0);
        xfer(2'b00, 2'b01, 1'b0, 1'b1, 32'h0000_9000, 32'h0, 1'b0, 1'b0);
        // R5: forbidden combinations.
        xfer(2'b10, 2'b00, 1'b0, 1'b0, 32'h0000_A000, 32'h0, 1'b0, 1'b0);
        xfer(2'b11, 2'b10, 1'b1, 1'b0, 32'h0000_B000, 32'h0, 1'b0, 1'b0);
        xfer(2'b11, 2'b01, 1'b0, 1'b1, 32'h0000_C000, 32'h0, 1'b0, 1'b0);
        // R12: start while busy is ignored.
        xfer(2'b00, 2'b11, 1'b0, 1'b0, 32'h0000_D000, 32'h0, 1'b1, 1'b1);
        xfer(2'b00, 2'b11, 1'b1, 1'b1, 32'h0000_0100, 32'h89AB_CDEF, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        chk(res_q.size() == 0 && beat_q.size() == 0, "R12 queues drained",
            32'(res_q.size()), 32'h0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule